// File: doc/BRIEF.md
# Per-block memory attribute mapper

This block sits between a CPU and the two memories of a 32K-word base address space: an EEPROM and a RAM. The space is cut into eight blocks of 4K words. Each block carries a 2-bit attribute, written by software through a small configuration port. The attribute decides which memory answers a read, which answers a write, and whether a write is allowed at all.

The decode is combinational from the word address and the read and write strobes. It produces a chip select and a write enable for each memory. One of the four attributes sends reads to EEPROM and writes to RAM at the same address. With that attribute, a plain loop that reads each word and writes it back copies ROM contents into the RAM underneath. Every block comes out of reset as read-only EEPROM, so the CPU boots from ROM.

Top module: `mem_attr_map`

## Requirements
- R1: The block index is address bits [14:12], giving eight 4K-word blocks. Each block uses only its own attribute.
- R2: After reset every block holds attribute 2'b00.
- R3: Attribute 2'b00 (EEPROM, read-only): a read asserts only rom_cs_o, and a write asserts no output.
- R4: Attribute 2'b01 (EEPROM, writeable): a read asserts only rom_cs_o, and a write asserts rom_cs_o and rom_we_o.
- R5: Attribute 2'b10 (RAM): a read asserts only ram_cs_o, and a write asserts ram_cs_o and ram_we_o.
- R6: Attribute 2'b11 (split): a read asserts only rom_cs_o, and a write asserts ram_cs_o and ram_we_o.
- R7: With neither strobe active, or with both active, every output is low.
- R8: An attribute write with cfg_we_i high is stored at the next rising clock edge. Before that edge the decode still uses the old value. Other blocks are left unchanged.
- R9: At most one chip select is active at a time, and a write enable is only asserted together with its own chip select during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 15 | CPU word address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| cfg_we_i | input | 1 | Attribute register write strobe |
| cfg_idx_i | input | 3 | Block whose attribute is written |
| cfg_attr_i | input | 2 | New attribute value |
| rom_cs_o | output | 1 | EEPROM chip select |
| rom_we_o | output | 1 | EEPROM write enable |
| ram_cs_o | output | 1 | RAM chip select |
| ram_we_o | output | 1 | RAM write enable |

## Verification
The bench loads four rotated attribute patterns. Across them, every block sees every attribute, and each pattern gives neighbouring blocks different attributes. This separates a wrong index slice from a wrong mode decode. For every block, the bench applies the idle, read, write and both-strobes inputs at the first, middle and last word of the block. These cases tell the four modes apart and catch edge bits taken from the wrong address field. A separate sequence changes one attribute while an access is held on that block. It checks the output before and after the clock edge, which exposes an update that is early, late or lost.

// File: rtl/mem_attr_pkg.sv
package mem_attr_pkg;
  typedef enum logic [1:0] {
    ATTR_ROM_RO = 2'b00,
    ATTR_ROM_RW = 2'b01,
    ATTR_RAM    = 2'b10,
    ATTR_SPLIT  = 2'b11
  } attr_e;
endpackage

// File: rtl/mem_attr_regs.sv
module mem_attr_regs #(
  parameter int BLK_W = 3,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [BLK_W-1:0]      idx_i,
  input  logic [1:0]            attr_i,
  output logic [NBLK-1:0][1:0]  tbl_o
);
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 tbl_o[b] <= mem_attr_pkg::ATTR_ROM_RO;
      else if (we_i && idx_i == BLK_W'(b))         tbl_o[b] <= attr_i;
    end
  end
endmodule

// File: rtl/mem_attr_decode.sv
module mem_attr_decode
  import mem_attr_pkg::*;
(
  input  logic [1:0] attr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  output logic       rom_cs_o,
  output logic       rom_we_o,
  output logic       ram_cs_o,
  output logic       ram_we_o
);
  logic rd_only, wr_only;
  attr_e mode;

  assign rd_only = rd_i & ~wr_i;
  assign wr_only = wr_i & ~rd_i;
  assign mode    = attr_e'(attr_i);

  always_comb begin
    rom_cs_o = 1'b0;
    rom_we_o = 1'b0;
    ram_cs_o = 1'b0;
    ram_we_o = 1'b0;
    unique case (mode)
      ATTR_ROM_RO: rom_cs_o = rd_only;
      ATTR_ROM_RW: begin
        rom_cs_o = rd_only | wr_only;
        rom_we_o = wr_only;
      end
      ATTR_RAM: begin
        ram_cs_o = rd_only | wr_only;
        ram_we_o = wr_only;
      end
      ATTR_SPLIT: begin
        rom_cs_o = rd_only;
        ram_cs_o = wr_only;
        ram_we_o = wr_only;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mem_attr_map.sv
module mem_attr_map #(
  parameter int ADDR_W = 15,
  parameter int BLK_W  = 3,
  localparam int NBLK  = 1 << BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              cfg_we_i,
  input  logic [BLK_W-1:0]  cfg_idx_i,
  input  logic [1:0]        cfg_attr_i,
  output logic              rom_cs_o,
  output logic              rom_we_o,
  output logic              ram_cs_o,
  output logic              ram_we_o
);
  logic [NBLK-1:0][1:0] tbl;
  logic [BLK_W-1:0]     blk;

  assign blk = addr_i[ADDR_W-1 -: BLK_W];

  mem_attr_regs #(.BLK_W(BLK_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .attr_i (cfg_attr_i),
    .tbl_o  (tbl)
  );

  mem_attr_decode u_dec (
    .attr_i   (tbl[blk]),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .rom_cs_o (rom_cs_o),
    .rom_we_o (rom_we_o),
    .ram_cs_o (ram_cs_o),
    .ram_we_o (ram_we_o)
  );
endmodule

// File: rtl/mem_attr_map_chk.sv
module mem_attr_map_chk #(
  parameter int ADDR_W = 15,
  parameter int BLK_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              cfg_we_i,
  input logic [BLK_W-1:0]  cfg_idx_i,
  input logic [1:0]        cfg_attr_i,
  input logic              rom_cs_o,
  input logic              rom_we_o,
  input logic              ram_cs_o,
  input logic              ram_we_o
);
  a_r9_one_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_cs_o && ram_cs_o));
  a_r9_rom_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_we_o |-> (rom_cs_o && wr_i && !rd_i));
  a_r9_ram_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_cs_o && wr_i && !rd_i));
  a_r7_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i == wr_i) |-> !(rom_cs_o || rom_we_o || ram_cs_o || ram_we_o));
  a_r8_ram_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_we_i && cfg_attr_i == 2'b10 && cfg_idx_i == addr_i[ADDR_W-1 -: BLK_W])
     && $stable(addr_i) && rd_i && !wr_i) |-> (ram_cs_o && !rom_cs_o));
endmodule

bind mem_attr_map mem_attr_map_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_attr_i(cfg_attr_i),
  .rom_cs_o(rom_cs_o), .rom_we_o(rom_we_o), .ram_cs_o(ram_cs_o), .ram_we_o(ram_we_o)
);

// File: tb/mem_attr_map_bench.sv
module mem_attr_map_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [1:0]  cfg_attr = '0;
  logic        rom_cs, rom_we, ram_cs, ram_we;

  int n_run = 0, n_fail = 0;
  logic [1:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_attr_map u_mem_attr_map (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_attr_i(cfg_attr),
    .rom_cs_o(rom_cs), .rom_we_o(rom_we), .ram_cs_o(ram_cs), .ram_we_o(ram_we)
  );

  // {rom_cs, rom_we, ram_cs, ram_we} per R3..R7
  function automatic logic [3:0] expect_out(logic [1:0] a, logic r, logic w);
    if (r == w) return 4'b0000;
    case (a)
      2'b00: return r ? 4'b1000 : 4'b0000;
      2'b01: return r ? 4'b1000 : 4'b1100;
      2'b10: return r ? 4'b0010 : 4'b0011;
      default: return r ? 4'b1000 : 4'b0011;
    endcase
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {rom_cs, rom_we, ram_cs, ram_we};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h rd=%0b wr=%0b actual=%b expected=%b", req, addr, rd, wr, act, exp);
    end
  endtask

  task automatic cfg_write(int idx, logic [1:0] a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_attr = a;
    @(negedge clk);
    cfg_we = 1'b0;
    model[idx] = a;
  endtask

  task automatic sweep(string req);
    for (int b = 0; b < 8; b++) begin
      for (int o = 0; o < 4; o++) begin
        for (int p = 0; p < 3; p++) begin
          @(negedge clk);
          addr = 15'(b * 4096 + (p == 0 ? 0 : (p == 1 ? 2047 : 4095)));
          rd = o[0]; wr = o[1];
          #1 check(req, expect_out(model[b], rd, wr));
        end
      end
    end
    rd = 1'b0; wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) model[b] = 2'b00;
    #(CLK_PERIOD * 2 + 2);
    // R2: reset state while reset held and after release
    addr = 15'h5000; rd = 1'b1;
    #1 check("R2", 4'b1000);
    rst_n = 1'b1;
    rd = 1'b0;
    sweep("R2 R3 R7");
    // R1 R3..R6 R9: rotated patterns so each block sees every mode
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 8; b++) cfg_write(b, 2'((b + k) % 4));
      sweep("R1 R3 R4 R5 R6 R7 R9");
    end
    // R8: update timing on block 5, neighbours untouched
    for (int b = 0; b < 8; b++) cfg_write(b, 2'b00);
    @(negedge clk);
    addr = 15'h5123; rd = 1'b1; wr = 1'b0;
    cfg_we = 1'b1; cfg_idx = 3'd5; cfg_attr = 2'b10;
    #1 check("R8 before edge", 4'b1000);
    @(posedge clk); #1;
    check("R8 after edge", 4'b0010);
    @(negedge clk);
    cfg_we = 1'b0; model[5] = 2'b10;
    wr = 1'b1; rd = 1'b0;
    #1 check("R8 write", 4'b0011);
    addr = 15'h4123;
    #1 check("R8 neighbour", 4'b0000);
    addr = 15'h6fff; wr = 1'b0; rd = 1'b1;
    #1 check("R8 neighbour", 4'b1000);
    rd = 1'b0;
    // R6: ROM shadow copy loop on block 2
    cfg_write(2, 2'b11);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); addr = 15'(8192 + i); rd = 1'b1; wr = 1'b0;
      #1 check("R6 copy read", 4'b1000);
      @(negedge clk); rd = 1'b0; wr = 1'b1;
      #1 check("R6 copy write", 4'b0011);
    end
    wr = 1'b0;
    // R2: asynchronous reset returns all blocks to read-only EEPROM
    @(negedge clk); rst_n = 1'b0;
    addr = 15'h5000; wr = 1'b1;
    #1 check("R2 reset write", 4'b0000);
    wr = 1'b0; rd = 1'b1;
    #1 check("R2 reset read", 4'b1000);
    rd = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule